// File: doc/BRIEF.md
# Receive Pad and FCS Stripper

This block sits in the receive path between the MAC byte stream and the receive FIFO. It watches each frame's length/type field. When stripping is enabled and that field gives an LLC payload shorter than the minimum, it cuts the frame down to the header plus the stated payload. It then discards both the pad and the trailing FCS, which would no longer match the shortened frame. Every other frame, including any frame whose field carries an Ethernet II type value, goes through byte for byte.

Input bytes arrive with a valid strobe and start and end markers. A per-frame enable is taken with the first byte of each frame. Output is a registered byte stream with valid and end markers, one cycle behind the input. CRC checking, address filtering and storage are handled elsewhere.

Top module: `rx_pad_strip`

## Requirements
- R1: While rst_ni is low, out_valid_o and out_eof_o are 0.
- R2: Every forwarded byte appears on out_data_o with out_valid_o high exactly one clock after it was accepted on the input, in input order, unchanged. The start-of-frame byte is always forwarded.
- R3: strip_en_i is sampled only on the start-of-frame byte. When it was 0 there, the whole frame is forwarded unmodified, with out_eof_o on the byte that carried in_eof_i. Changes to strip_en_i later in the frame have no effect.
- R4: The length/type value is formed from frame bytes 12 (most significant) and 13 (least significant), where byte 0 is the first destination byte.
- R5: With stripping enabled and a length value below 46, exactly 14 + length bytes are forwarded, and out_eof_o is raised on the last of them.
- R6: With a length value of 46 or more, including type values such as 0x0800, the frame is forwarded unmodified.
- R7: After the last kept byte of a stripped frame, no further input byte of that frame is forwarded. The next start-of-frame byte is forwarded normally.
- R8: If in_eof_i arrives before the computed kept length is reached, the frame is forwarded as received, with out_eof_o on the original last byte.
- R9: A length value of 0 keeps exactly the 14 header bytes, and the end marker is placed on byte 13.
- R10: Frames shorter than 14 bytes are forwarded unmodified.
- R11: Cycles with in_valid_i low produce no output and do not advance the frame position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strip_en_i | input | 1 | Enables stripping; sampled on the start-of-frame byte |
| in_valid_i | input | 1 | Input byte valid |
| in_sof_i | input | 1 | Input byte is the first of a frame |
| in_eof_i | input | 1 | Input byte is the last of a frame |
| in_data_i | input | 8 | Input byte |
| out_valid_o | output | 1 | Output byte valid |
| out_eof_o | output | 1 | Output byte is the last of the forwarded frame |
| out_data_o | output | 8 | Output byte |

## Verification
Each accepted input byte has a result due exactly one clock later. That result is either the byte itself on the output, or a quiet output if the byte falls in the discarded tail or is an idle cycle. The bench drives each byte on the falling edge and samples the outputs shortly after the next rising edge. Each sample is then matched against the byte driven one edge earlier. For a cut frame, the moved end marker is due in the cycle that follows the acceptance of byte 13 + length. The bench checks it there, and checks that every later byte of the same frame gives nothing.

// File: rtl/rx_strip_pkg.sv
package rx_strip_pkg;
  typedef enum logic [1:0] {
    MODE_PASS,
    MODE_TRIM,
    MODE_DROP
  } strip_mode_e;
endpackage

// File: rtl/rx_strip_cnt.sv
module rx_strip_cnt #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  output logic [CNT_W-1:0] idx_o
);
  logic [CNT_W-1:0] idx_q;

  assign idx_o = sof_i ? '0 : idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else if (valid_i && idx_o != '1) begin
      idx_q <= idx_o + 1'b1;  // saturates on very long frames
    end
  end
endmodule

// File: rtl/rx_strip_len.sv
module rx_strip_len #(
  parameter int CNT_W     = 11,
  parameter int HDR_BYTES = 14,
  parameter int MIN_LEN   = 46,
  parameter int LEN_POS   = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic [7:0]       data_i,
  output logic             len_rdy_o,
  output logic             short_o,
  output logic [CNT_W-1:0] keep_last_o
);
  localparam logic [CNT_W-1:0] HI_IDX   = CNT_W'(LEN_POS);
  localparam logic [CNT_W-1:0] LO_IDX   = CNT_W'(LEN_POS + 1);
  localparam logic [CNT_W-1:0] LAST_HDR = CNT_W'(HDR_BYTES - 1);

  logic [7:0]  hi_q;
  logic [15:0] len_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         hi_q <= '0;
    else if (valid_i && idx_i == HI_IDX) hi_q <= data_i;
  end

  assign len_w       = {hi_q, data_i};
  assign len_rdy_o   = valid_i && idx_i == LO_IDX;
  assign short_o     = len_w < 16'(MIN_LEN);
  // only meaningful when short_o, so truncation is safe
  assign keep_last_o = LAST_HDR + len_w[CNT_W-1:0];
endmodule

// File: rtl/rx_strip_fsm.sv
module rx_strip_fsm
  import rx_strip_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic             eof_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic             len_rdy_i,
  input  logic             short_i,
  input  logic [CNT_W-1:0] keep_last_i,
  output logic             fwd_o,
  output logic             eof_o
);
  strip_mode_e      mode_q, mode_cur, mode_d;
  logic [CNT_W-1:0] last_q, last_d;
  logic             en_q, frm_en, cut;

  assign frm_en   = sof_i ? en_i : en_q;
  assign mode_cur = sof_i ? MODE_PASS : mode_q;

  always_comb begin
    fwd_o  = 1'b1;
    cut    = 1'b0;
    mode_d = mode_cur;
    last_d = last_q;
    unique case (mode_cur)
      MODE_PASS: begin
        if (len_rdy_i && frm_en && short_i) begin
          if (idx_i == keep_last_i) begin
            cut    = 1'b1;
            mode_d = MODE_DROP;
          end else begin
            mode_d = MODE_TRIM;
            last_d = keep_last_i;
          end
        end
      end
      MODE_TRIM: begin
        if (idx_i == last_q) begin
          cut    = 1'b1;
          mode_d = MODE_DROP;
        end
      end
      default: fwd_o = 1'b0;
    endcase
    if (eof_i) mode_d = MODE_PASS;
    eof_o = eof_i | cut;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_PASS;
      last_q <= '0;
      en_q   <= 1'b0;
    end else if (valid_i) begin
      mode_q <= mode_d;
      last_q <= last_d;
      en_q   <= frm_en;
    end
  end
endmodule

// File: rtl/rx_pad_strip.sv
module rx_pad_strip #(
  parameter int CNT_W     = 11,
  parameter int HDR_BYTES = 14,
  parameter int MIN_LEN   = 46,
  parameter int LEN_POS   = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strip_en_i,
  input  logic       in_valid_i,
  input  logic       in_sof_i,
  input  logic       in_eof_i,
  input  logic [7:0] in_data_i,
  output logic       out_valid_o,
  output logic       out_eof_o,
  output logic [7:0] out_data_o
);
  logic [CNT_W-1:0] idx, keep_last;
  logic             len_rdy, short_len, fwd, eof_cut;
  logic             valid_q, eof_q;
  logic [7:0]       data_q;

  rx_strip_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(in_valid_i),
    .sof_i  (in_sof_i),
    .idx_o  (idx)
  );

  rx_strip_len #(
    .CNT_W(CNT_W), .HDR_BYTES(HDR_BYTES), .MIN_LEN(MIN_LEN), .LEN_POS(LEN_POS)
  ) u_len (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (in_valid_i),
    .idx_i      (idx),
    .data_i     (in_data_i),
    .len_rdy_o  (len_rdy),
    .short_o    (short_len),
    .keep_last_o(keep_last)
  );

  rx_strip_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (in_valid_i),
    .sof_i      (in_sof_i),
    .eof_i      (in_eof_i),
    .en_i       (strip_en_i),
    .idx_i      (idx),
    .len_rdy_i  (len_rdy),
    .short_i    (short_len),
    .keep_last_i(keep_last),
    .fwd_o      (fwd),
    .eof_o      (eof_cut)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      eof_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= in_valid_i & fwd;
      eof_q   <= in_valid_i & fwd & eof_cut;
      if (in_valid_i) data_q <= in_data_i;
    end
  end

  assign out_valid_o = valid_q;
  assign out_eof_o   = eof_q;
  assign out_data_o  = data_q;
endmodule

// File: rtl/rx_pad_strip_chk.sv
module rx_pad_strip_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       strip_en_i,
  input logic       in_valid_i,
  input logic       in_sof_i,
  input logic       in_eof_i,
  input logic [7:0] in_data_i,
  input logic       out_valid_o,
  input logic       out_eof_o,
  input logic [7:0] out_data_o
);
  logic en_frm_q, en_cur, in_eof_d_q, trimmed_q, trim_now, drop_act;

  assign en_cur   = in_sof_i ? strip_en_i : en_frm_q;
  assign trim_now = out_valid_o && out_eof_o && !in_eof_d_q;
  assign drop_act = trim_now || trimmed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_frm_q   <= 1'b0;
      in_eof_d_q <= 1'b0;
      trimmed_q  <= 1'b0;
    end else begin
      in_eof_d_q <= in_valid_i && in_eof_i;
      if (in_valid_i) en_frm_q <= en_cur;
      if (in_valid_i && in_sof_i) trimmed_q <= 1'b0;
      else if (trim_now)          trimmed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_QUIET: assert (!out_valid_o && !out_eof_o);  // R1
  end

  AST_OUT_NEEDS_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i));  // R2
  AST_SOF_FORWARDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_sof_i) |=> out_valid_o);  // R2
  AST_EOF_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_eof_o |-> out_valid_o);  // R5
  AST_DISABLED_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !en_cur) |=> (out_valid_o && out_data_o == $past(in_data_i)
                                 && out_eof_o == $past(in_eof_i)));  // R3
  AST_TAIL_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_act && in_valid_i && !in_sof_i) |=> !out_valid_o);  // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);  // R11
endmodule

bind rx_pad_strip rx_pad_strip_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .strip_en_i (strip_en_i),
  .in_valid_i (in_valid_i),
  .in_sof_i   (in_sof_i),
  .in_eof_i   (in_eof_i),
  .in_data_i  (in_data_i),
  .out_valid_o(out_valid_o),
  .out_eof_o  (out_eof_o),
  .out_data_o (out_data_o)
);

// File: tb/rx_pad_strip_tb.sv
module rx_pad_strip_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  typedef struct packed {
    logic        en;
    logic [15:0] len;
    logic [7:0]  total;
    logic        gap;
    logic [7:0]  exp;
    logic [3:0]  req;
  } vec_t;

  // en, length/type, bytes in, idle gaps, bytes out, requirement
  localparam vec_t VECS [11] = '{
    '{1'b1, 16'd0,      8'd64, 1'b0, 8'd14, 4'd9},   // R9
    '{1'b1, 16'd10,     8'd64, 1'b0, 8'd24, 4'd5},   // R5
    '{1'b1, 16'd45,     8'd64, 1'b0, 8'd59, 4'd5},   // R5 boundary
    '{1'b1, 16'd46,     8'd64, 1'b0, 8'd64, 4'd6},   // R6 boundary
    '{1'b1, 16'h0800,   8'd64, 1'b0, 8'd64, 4'd6},   // R6 type value
    '{1'b0, 16'd10,     8'd64, 1'b0, 8'd64, 4'd3},   // R3
    '{1'b1, 16'd40,     8'd30, 1'b0, 8'd30, 4'd8},   // R8
    '{1'b1, 16'd3,      8'd10, 1'b0, 8'd10, 4'd10},  // R10
    '{1'b1, 16'd20,     8'd64, 1'b1, 8'd34, 4'd11},  // R11
    '{1'b1, 16'd20,     8'd34, 1'b0, 8'd34, 4'd5},   // R5 exact end
    '{1'b1, 16'h0102,   8'd64, 1'b0, 8'd64, 4'd4}    // R4 high byte counts
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic       strip_en_i = 1'b0;
  logic       in_valid_i = 1'b0;
  logic       in_sof_i = 1'b0;
  logic       in_eof_i = 1'b0;
  logic [7:0] in_data_i = '0;
  logic       out_valid_o, out_eof_o;
  logic [7:0] out_data_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  rx_pad_strip u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strip_en_i (strip_en_i),
    .in_valid_i (in_valid_i),
    .in_sof_i   (in_sof_i),
    .in_eof_i   (in_eof_i),
    .in_data_i  (in_data_i),
    .out_valid_o(out_valid_o),
    .out_eof_o  (out_eof_o),
    .out_data_o (out_data_o)
  );

  function automatic logic [7:0] frame_byte(int i, logic [15:0] len);
    if (i == 12) return len[15:8];
    if (i == 13) return len[7:0];
    return 8'(i * 37 + 5);
  endfunction

  task automatic idle();
    @(negedge clk_i);
    in_valid_i = 1'b0;
    in_sof_i   = 1'b0;
    in_eof_i   = 1'b0;
    @(posedge clk_i);
    #1;
  endtask

  task automatic run_frame(input logic en0, input logic en1, input logic [15:0] len,
                           input int total, input logic gap, input int exp, input string req);
    logic bad = 1'b0;
    checks++;
    for (int i = 0; i < total; i++) begin
      logic [7:0] b;
      logic       ev, ee;
      b = frame_byte(i, len);
      @(negedge clk_i);
      in_valid_i = 1'b1;
      in_sof_i   = (i == 0);
      in_eof_i   = (i == total - 1);
      in_data_i  = b;
      strip_en_i = (i == 0) ? en0 : en1;
      @(posedge clk_i);
      #1;
      ev = (i < exp);
      ee = (i == exp - 1);
      if (!bad && (out_valid_o !== ev ||
                   (ev && (out_data_o !== b || out_eof_o !== ee)))) begin
        bad = 1'b1;
        fails++;
        $display("FAIL %s byte %0d: valid/eof/data %b/%b/%h, expected %b/%b/%h",
                 req, i, out_valid_o, out_eof_o, out_data_o, ev, ee, b);
      end
      if (gap && i != total - 1) begin
        idle();
        if (!bad && out_valid_o !== 1'b0) begin
          bad = 1'b1;
          fails++;
          $display("FAIL %s gap after byte %0d: valid %b, expected 0", req, i, out_valid_o);
        end
      end
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog: run still active after %0d cycles, expected done", WD_CYCLES);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2 rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    checks++;  // R1
    if (out_valid_o !== 1'b0 || out_eof_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: valid/eof %b/%b, expected 0/0", out_valid_o, out_eof_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle();

    foreach (VECS[k]) begin
      run_frame(VECS[k].en, VECS[k].en, VECS[k].len, int'(VECS[k].total),
                VECS[k].gap, int'(VECS[k].exp), $sformatf("R%0d", VECS[k].req));
      idle();
    end

    // R3: enable raised after the start byte is ignored
    run_frame(1'b0, 1'b1, 16'd10, 64, 1'b0, 64, "R3");
    idle();
    // R3: enable dropped after the start byte is ignored
    run_frame(1'b1, 1'b0, 16'd10, 64, 1'b0, 24, "R3");
    idle();
    // R7: cut frame followed at once by a full frame
    run_frame(1'b1, 1'b1, 16'd5, 64, 1'b0, 19, "R7");
    run_frame(1'b1, 1'b1, 16'h0600, 64, 1'b0, 64, "R7");
    idle();
    // R9: zero length, frame ends right on byte 13
    run_frame(1'b1, 1'b1, 16'd0, 14, 1'b0, 14, "R9");
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule